// File: doc/BRIEF.md
# Load-Store ALU with Condition Flags

This block is the data-processing stage of a small load-store RISC core. It takes two source operands, an accumulate operand and a 4-bit operation code, and returns a result with a register-write enable. The result and the write enable are combinational. It also keeps four condition flags in a status register: negative, zero, carry and overflow.

The supported work covers several groups. Arithmetic includes add, subtract and reversed subtract, plus add and subtract with carry, which take the carry flag held in the status register. The bitwise group covers and, or, exclusive-or, bit clear, move and move-complement. Four compare-only operations update the flags and never write a register. Multiply-accumulate is also provided.

Operand shifting happens outside the block. The shifter's carry-out arrives on `shift_carry` and becomes the carry flag for the bitwise operations.

Top module: `load_store_alu`

## Requirements
- R1: Opcode 0100 adds `src_a` and `src_b`. Opcode 1011 does the same addition for flags only. An addition's carry flag is the carry-out of bit WIDTH-1.
- R2: Opcode 0010 computes `src_a - src_b` and opcode 1010 does the same for flags only. For a subtraction, C is 1 exactly when no borrow occurs, that is when `src_a >= src_b` unsigned.
- R3: Opcode 0101 computes `src_a + src_b + C`. Opcode 0110 computes `src_a - src_b - (1 - C)`. In both, C is the carry flag held before the clock edge.
- R4: Opcode 0011 computes the reversed difference `src_b - src_a`. Its C is 1 when `src_b >= src_a` unsigned.
- R5: The bitwise opcodes are 0000 (and), 1100 (or), 0001 (exclusive-or) and 1110 (bit clear, `src_a & ~src_b`). Each 1 bit of `src_b` clears the matching result bit under bit clear.
- R6: Opcode 1101 passes `src_b` and opcode 1111 passes `~src_b`.
- R7: Opcodes 1000 (and), 1001 (exclusive-or), 1010 (subtract) and 1011 (add) are compare-only. They hold `wr_en` low and update the flags even when `set_flags` is low. Every other opcode drives `wr_en` high.
- R8: Opcode 0111 returns the low WIDTH bits of `src_a * src_b + src_acc`. It updates N and Z and leaves C and V unchanged.
- R9: The status word holds N, Z, C and V in bits WIDTH-1, WIDTH-2, WIDTH-3 and WIDTH-4. All lower bits read 0. N is the top bit of the result and Z is set when the result is zero.
- R10: V is set when the two adder inputs share a sign and the sum's sign differs. For a subtraction, the adder inputs are the minuend and the negated subtrahend.
- R11: For the bitwise and move opcodes, C takes `shift_carry` and V is unchanged.
- R12: On an edge where `set_flags` is low and the opcode is not compare-only, the status word holds its value.
- R13: A synchronous `rst` clears all four flags on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op | input | 4 | Operation code |
| src_a | input | WIDTH | First operand |
| src_b | input | WIDTH | Second (shifted) operand |
| src_acc | input | WIDTH | Accumulate operand for multiply-accumulate |
| set_flags | input | 1 | Let this operation update the flags |
| shift_carry | input | 1 | Carry-out from the operand shifter |
| result | output | WIDTH | Operation result |
| wr_en | output | 1 | Destination register write enable |
| status | output | WIDTH | Status word with NZCV in the top four bits |

## Verification
The bench builds the block with the default WIDTH of 32 and models every opcode with 64-bit signed and unsigned integers, so the signed-overflow limits 0x7FFFFFFF/0x80000000 and the all-ones carry boundary are reached directly. With 32 bits, the wrap of the multiply-accumulate product is visible. The carry-in paths of the with-carry forms are driven from both flag states.

// File: rtl/load_store_alu.sv
module load_store_alu #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic [WIDTH-1:0] src_acc,
  input  logic             set_flags,
  input  logic             shift_carry,
  output logic [WIDTH-1:0] result,
  output logic             wr_en,
  output logic [WIDTH-1:0] status
);

  localparam int MSB = WIDTH - 1;

  localparam logic [3:0] OP_AND = 4'b0000;
  localparam logic [3:0] OP_XOR = 4'b0001;
  localparam logic [3:0] OP_SUB = 4'b0010;
  localparam logic [3:0] OP_RSB = 4'b0011;
  localparam logic [3:0] OP_ADD = 4'b0100;
  localparam logic [3:0] OP_ADC = 4'b0101;
  localparam logic [3:0] OP_SBC = 4'b0110;
  localparam logic [3:0] OP_MAC = 4'b0111;
  localparam logic [3:0] OP_TST = 4'b1000;
  localparam logic [3:0] OP_TEQ = 4'b1001;
  localparam logic [3:0] OP_CMP = 4'b1010;
  localparam logic [3:0] OP_CMN = 4'b1011;
  localparam logic [3:0] OP_ORR = 4'b1100;
  localparam logic [3:0] OP_MOV = 4'b1101;
  localparam logic [3:0] OP_BIC = 4'b1110;
  localparam logic [3:0] OP_MVN = 4'b1111;

  logic [3:0]       flags_q;   // N Z C V
  logic [3:0]       flags_d;
  logic [WIDTH-1:0] add_x, add_y;
  logic             add_cin;
  logic [WIDTH:0]   add_sum;
  logic             add_v;
  logic             is_arith, is_mac, is_cmp;
  logic [WIDTH-1:0] mac_val;

  assign status  = {flags_q, {(WIDTH-4){1'b0}}};
  assign is_cmp  = (op[3:2] == 2'b10);
  assign is_mac  = (op == OP_MAC);
  assign wr_en   = !is_cmp;

  always_comb begin
    is_arith = 1'b1;
    add_x    = src_a;
    add_y    = src_b;
    add_cin  = 1'b0;
    case (op)
      OP_SUB, OP_CMP: begin add_y = ~src_b; add_cin = 1'b1; end
      OP_RSB:         begin add_x = src_b; add_y = ~src_a; add_cin = 1'b1; end
      OP_ADC:         add_cin = flags_q[1];
      OP_SBC:         begin add_y = ~src_b; add_cin = flags_q[1]; end
      OP_ADD, OP_CMN: ;
      default:        is_arith = 1'b0;
    endcase
  end

  assign add_sum = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_cin};
  assign add_v   = (add_x[MSB] == add_y[MSB]) && (add_sum[MSB] != add_x[MSB]);
  assign mac_val = src_a * src_b + src_acc;

  always_comb begin
    case (op)
      OP_AND, OP_TST: result = src_a & src_b;
      OP_XOR, OP_TEQ: result = src_a ^ src_b;
      OP_ORR:         result = src_a | src_b;
      OP_BIC:         result = src_a & ~src_b;
      OP_MOV:         result = src_b;
      OP_MVN:         result = ~src_b;
      OP_MAC:         result = mac_val;
      default:        result = add_sum[MSB:0];
    endcase
  end

  always_comb begin
    flags_d[3] = result[MSB];
    flags_d[2] = (result == '0);
    if (is_arith) begin
      flags_d[1] = add_sum[WIDTH];
      flags_d[0] = add_v;
    end else if (is_mac) begin
      flags_d[1:0] = flags_q[1:0];
    end else begin
      flags_d[1] = shift_carry;
      flags_d[0] = flags_q[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                       flags_q <= 4'b0000;
    else if (set_flags || is_cmp)  flags_q <= flags_d;
  end

  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (rst)
    (op[3:2] == 2'b10) |-> !wr_en);

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!set_flags && op[3:2] != 2'b10) |=> $stable(status));

  assert_low_bits_zero_R9: assert property (@(posedge clk) disable iff (rst)
    status[WIDTH-5:0] == '0);

  assert_logic_keeps_v_R11: assert property (@(posedge clk) disable iff (rst)
    (set_flags && (op == OP_ORR || op == OP_MOV || op == OP_BIC || op == OP_MVN))
      |=> status[WIDTH-4] == $past(status[WIDTH-4]));

  assert_mac_keeps_cv_R8: assert property (@(posedge clk) disable iff (rst)
    (set_flags && op == OP_MAC) |=> status[WIDTH-3:WIDTH-4] == $past(status[WIDTH-3:WIDTH-4]));

  assert_add_sum_R1: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADD) |-> result == src_a + src_b);

  assert_reset_clears_R13: assert property (@(posedge clk)
    rst |=> status == '0);

endmodule

// File: tb/test_load_store_alu.sv
module test_load_store_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = 4'h4;
  logic [31:0] src_a = '0, src_b = '0, src_acc = '0;
  logic        set_flags = 1'b0, shift_carry = 1'b0;
  logic [31:0] result, status;
  logic        wr_en;

  int n_run = 0, n_fail = 0;
  logic [3:0] ref_fl = 4'b0000;

  always #4 clk = ~clk;

  load_store_alu #(.WIDTH(32)) i_load_store_alu (
    .clk(clk), .rst(rst), .op(op), .src_a(src_a), .src_b(src_b), .src_acc(src_acc),
    .set_flags(set_flags), .shift_carry(shift_carry),
    .result(result), .wr_en(wr_en), .status(status));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit ovf(input longint v);
    return (v > 64'sd2147483647) || (v < -64'sd2147483648);
  endfunction

  function automatic void model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                                input logic [31:0] acc, input logic sc, input logic [3:0] fl,
                                output logic [31:0] r, output logic we, output logic [3:0] nf);
    longint sa, sb, ua, ub, ci, t;
    logic c, v;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = longint'({32'b0, a}); ub = longint'({32'b0, b});
    ci = fl[1] ? 64'sd1 : 64'sd0;
    c = sc; v = fl[0];
    case (o)
      4'h4, 4'hB: begin t = ua + ub; r = t[31:0]; c = t[32]; v = ovf(sa + sb); end
      4'h2, 4'hA: begin r = a - b; c = (ua >= ub); v = ovf(sa - sb); end
      4'h3:       begin r = b - a; c = (ub >= ua); v = ovf(sb - sa); end
      4'h5:       begin t = ua + ub + ci; r = t[31:0]; c = t[32]; v = ovf(sa + sb + ci); end
      4'h6:       begin t = ua - ub - (1 - ci); r = t[31:0]; c = (ua >= ub + (1 - ci));
                        v = ovf(sa - sb - (1 - ci)); end
      4'h7:       begin t = ua * ub + longint'({32'b0, acc}); r = t[31:0]; c = fl[1]; v = fl[0]; end
      4'h0, 4'h8: r = a & b;
      4'h1, 4'h9: r = a ^ b;
      4'hC:       r = a | b;
      4'hD:       r = b;
      4'hE:       r = a & ~b;
      default:    r = ~b;
    endcase
    we = !(o[3:2] == 2'b10);
    nf = {r[31], (r == 32'b0), c, v};
  endfunction

  task automatic step(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] acc, input logic sf, input logic sc, input string tag);
    logic [31:0] er; logic ew; logic [3:0] nf;
    op = o; src_a = a; src_b = b; src_acc = acc; set_flags = sf; shift_carry = sc;
    #2;
    model(o, a, b, acc, sc, ref_fl, er, ew, nf);
    chk(result === er, {tag, " result"}, result, er);
    chk(wr_en === ew, {tag, " R7 wr_en"}, {31'b0, wr_en}, {31'b0, ew});
    @(posedge clk);
    if (sf || o[3:2] == 2'b10) ref_fl = nf;
    #1;
    chk(status === {ref_fl, 28'b0}, {tag, " R9 status"}, status, {ref_fl, 28'b0});
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(posedge clk); @(posedge clk); #1;
    chk(status === 32'b0, "R13 reset", status, 32'b0);
    rst = 1'b0;

    step(4'h4, 32'd5, 32'd7, 0, 1, 0, "R1 add");
    step(4'h4, 32'h7FFF_FFFF, 32'd1, 0, 1, 0, "R10 add overflow");
    step(4'h4, 32'hFFFF_FFFF, 32'd1, 0, 1, 0, "R1 add carry zero");
    step(4'h2, 32'd9, 32'd9, 0, 1, 0, "R2 sub equal");
    step(4'h2, 32'd1, 32'd2, 0, 1, 0, "R2 sub borrow");
    step(4'h2, 32'h8000_0000, 32'd1, 0, 1, 0, "R10 sub overflow");
    step(4'h3, 32'd3, 32'd10, 0, 1, 0, "R4 rsb");
    step(4'h3, 32'd10, 32'd3, 0, 1, 0, "R4 rsb borrow");
    step(4'h4, 32'hFFFF_FFFF, 32'd2, 0, 1, 0, "R1 set carry");
    step(4'h5, 32'd10, 32'd20, 0, 1, 0, "R3 adc carry in 1");
    step(4'h5, 32'd10, 32'd20, 0, 1, 0, "R3 adc carry in 0");
    step(4'h6, 32'd10, 32'd3, 0, 1, 0, "R3 sbc carry in 0");
    step(4'h6, 32'd10, 32'd3, 0, 1, 0, "R3 sbc carry in 1");
    step(4'h0, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 1, 1, "R5 and");
    step(4'hC, 32'hF000_0000, 32'h0000_000F, 0, 1, 0, "R5 orr");
    step(4'h1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 1, 1, "R5 xor zero");
    step(4'hE, 32'hFFFF_FFFF, 32'h0000_FF00, 0, 1, 0, "R5 bic");
    step(4'h2, 32'h8000_0000, 32'd1, 0, 1, 0, "R10 set V");
    step(4'hD, 32'd0, 32'h8000_0001, 0, 1, 1, "R11 mov keeps V");
    step(4'hF, 32'd0, 32'h0000_0000, 0, 1, 0, "R6 mvn");
    step(4'h7, 32'h0001_0000, 32'h0001_0003, 32'd7, 1, 0, "R8 mac wrap");
    step(4'h7, 32'd0, 32'd5, 32'd0, 1, 1, "R8 mac zero");
    step(4'h8, 32'h0000_00F0, 32'h0000_000F, 0, 0, 1, "R7 tst");
    step(4'h9, 32'h1234_5678, 32'h1234_5678, 0, 0, 0, "R7 teq");
    step(4'hA, 32'd4, 32'd9, 0, 0, 0, "R7 cmp");
    step(4'hB, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, "R7 cmn");
    step(4'h4, 32'd0, 32'd0, 0, 0, 1, "R12 add no flags");
    step(4'hF, 32'd1, 32'd0, 0, 0, 1, "R12 mvn no flags");

    rst = 1'b1;
    @(posedge clk); #1;
    ref_fl = 4'b0000;
    chk(status === 32'b0, "R13 reset mid run", status, 32'b0);
    rst = 1'b0;
    step(4'h4, 32'd1, 32'd1, 0, 1, 0, "R1 after reset");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule